// File: doc/BRIEF.md
# LPC Host SYNC Timeout Monitor

This block sits on the host side of a Low Pin Count bus and watches the four LAD lines while a peripheral is in the SYNC phase of a cycle. A one-clock start strobe arms it. From the next clock on, it classifies every sampled nibble. It ends the phase as soon as it sees a ready code or an error code. It aborts the phase when the peripheral stops producing legal SYNC values, or when a short wait runs longer than the bus allows.

The result is reported as a single-cycle `done` or `abort` pulse. `done` carries two qualifier flags. One tells which ready code ended the phase. The other marks that the peripheral reported an error. The monitor does not drive LAD or generate the bus abort sequence. Bus control logic consumes the pulses.

FSM states: `ST_IDLE` (not armed), `ST_HUNT` (armed, no wait code seen in the current run), `ST_SHORT` (inside a run of short-wait codes) and `ST_LONG` (inside a run of long-wait codes).

FSM transitions:
- `ST_IDLE`→`ST_HUNT` on the start strobe.
- Any armed state→`ST_SHORT` on 0101.
- Any armed state→`ST_LONG` on 0110.
- Any armed state→`ST_HUNT` on an illegal nibble that is not yet the third in a row.
- Any armed state→`ST_IDLE` on a ready code, the error code, the third illegal nibble in a row, or the ninth consecutive 0101.

Top module: `lpc_sync_watch`

## Requirements
- R1: After reset, `done`, `abort`, `rdy_alt` and `err_sync` are all 0 and the monitor is idle.
- R2: A high `sync_start` while idle arms the monitor, and the first nibble classified is the one sampled on the following clock. While idle, LAD values have no effect. A `sync_start` while armed is ignored.
- R3: A nibble other than 0000, 0101, 0110, 1001 or 1010 is illegal. Three illegal nibbles on consecutive armed clocks cause `abort`. Any legal nibble restarts that count from zero.
- R4: Up to 8 consecutive 0101 nibbles are tolerated. The ninth consecutive 0101 causes `abort`. Any other nibble restarts the 0101 run count.
- R5: Consecutive 0110 nibbles are tolerated without limit and never cause `abort`.
- R6: Nibble 0000 ends the phase with `done`=1, `rdy_alt`=0 and `err_sync`=0. Nibble 1001 ends it with `done`=1 and `rdy_alt`=1.
- R7: Nibble 1010 ends the phase with `done`=1, `err_sync`=1 and `rdy_alt`=0.
- R8: `done` and `abort` are registered one-clock pulses. Each appears in the cycle after the deciding nibble is sampled, and the two are never high together. `rdy_alt` and `err_sync` are 0 whenever `done` is 0. After either pulse the monitor is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_start | input | 1 | One-clock strobe; the SYNC phase begins on the next clock |
| lad_in | input | 4 | Sampled LAD nibble |
| done | output | 1 | Pulse: SYNC phase completed |
| abort | output | 1 | Pulse: SYNC phase must be aborted |
| rdy_alt | output | 1 | With `done`: ended by 1001 rather than 0000 |
| err_sync | output | 1 | With `done`: ended by the error code 1010 |

## Verification
The bench tests the exact boundaries of both bounded counts:
- Eight 0101 then a ready code must complete, while nine 0101 must abort. An off-by-one limit flips one of these two outcomes.
- Two illegal nibbles, then a wait code, then two more illegal nibbles must not abort. A design that fails to clear the miss count on a legal code aborts there.
- Long runs of 0110 check that a design limiting the long wait aborts early.
- Start strobes sent mid-phase and LAD noise while idle check that a design that re-arms, or decodes while unarmed, produces extra or shifted pulses.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] CODE_READY     = 4'b0000;
    localparam logic [NIB_W-1:0] CODE_WAIT_SHRT = 4'b0101;
    localparam logic [NIB_W-1:0] CODE_WAIT_LONG = 4'b0110;
    localparam logic [NIB_W-1:0] CODE_READY_ALT = 4'b1001;
    localparam logic [NIB_W-1:0] CODE_ERROR     = 4'b1010;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_SHORT,
        ST_LONG
    } sync_state_e;

    typedef enum logic [2:0] {
        K_READY,
        K_READY_ALT,
        K_WAIT_SHRT,
        K_WAIT_LONG,
        K_ERROR,
        K_ILLEGAL
    } nib_kind_e;

endpackage

// File: rtl/lpc_sync_decode.sv
module lpc_sync_decode
    import lpc_sync_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output nib_kind_e        kind,
    output logic             legal
);

    always_comb begin
        unique case (nib)
            CODE_READY:     kind = K_READY;
            CODE_READY_ALT: kind = K_READY_ALT;
            CODE_WAIT_SHRT: kind = K_WAIT_SHRT;
            CODE_WAIT_LONG: kind = K_WAIT_LONG;
            CODE_ERROR:     kind = K_ERROR;
            default:        kind = K_ILLEGAL;
        endcase
    end

    assign legal = (kind != K_ILLEGAL);

endmodule

// File: rtl/lpc_run_cnt.sv
module lpc_run_cnt #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);

    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = inc && !clr && (cnt_q == LAST);

endmodule

// File: rtl/lpc_sync_watch.sv
module lpc_sync_watch
    import lpc_sync_pkg::*;
#(
    parameter int MISS_LIMIT  = 3,
    parameter int SHORT_LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_start,
    input  logic [NIB_W-1:0] lad_in,
    output logic             done,
    output logic             abort,
    output logic             rdy_alt,
    output logic             err_sync
);

    localparam int SHORT_ABORT_AT = SHORT_LIMIT + 1;

    sync_state_e state_q, state_d;
    nib_kind_e   kind;
    logic        legal;
    logic        watching;
    logic        miss_hit, short_hit;
    logic        done_d, abort_d, alt_d, err_d;

    lpc_sync_decode u_dec (
        .nib   (lad_in),
        .kind  (kind),
        .legal (legal)
    );

    assign watching = (state_q != ST_IDLE);

    // consecutive clocks without a legal SYNC value
    lpc_run_cnt #(.LIMIT(MISS_LIMIT)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!watching || legal),
        .inc   (watching && !legal),
        .hit   (miss_hit)
    );

    // consecutive short-wait codes
    lpc_run_cnt #(.LIMIT(SHORT_ABORT_AT)) u_short (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!watching || (kind != K_WAIT_SHRT)),
        .inc   (watching && (kind == K_WAIT_SHRT)),
        .hit   (short_hit)
    );

    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        abort_d = 1'b0;
        alt_d   = 1'b0;
        err_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sync_start) begin
                    state_d = ST_HUNT;
                end
            end
            ST_HUNT, ST_SHORT, ST_LONG: begin
                unique case (kind)
                    K_READY: begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end
                    K_READY_ALT: begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                        alt_d   = 1'b1;
                    end
                    K_ERROR: begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                        err_d   = 1'b1;
                    end
                    K_WAIT_SHRT: begin
                        if (short_hit) begin
                            state_d = ST_IDLE;
                            abort_d = 1'b1;
                        end else begin
                            state_d = ST_SHORT;
                        end
                    end
                    K_WAIT_LONG: begin
                        state_d = ST_LONG;
                    end
                    K_ILLEGAL: begin
                        if (miss_hit) begin
                            state_d = ST_IDLE;
                            abort_d = 1'b1;
                        end else begin
                            state_d = ST_HUNT;
                        end
                    end
                    default: begin
                        state_d = ST_IDLE;
                        abort_d = 1'b1;
                    end
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            abort    <= 1'b0;
            rdy_alt  <= 1'b0;
            err_sync <= 1'b0;
        end else begin
            done     <= done_d;
            abort    <= abort_d;
            rdy_alt  <= alt_d;
            err_sync <= err_d;
        end
    end

endmodule

// File: rtl/lpc_sync_watch_chk.sv
module lpc_sync_watch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_start,
    input logic [3:0] lad_in,
    input logic       watching,
    input logic       done,
    input logic       abort,
    input logic       rdy_alt,
    input logic       err_sync
);

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && abort)); // R8

    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_ABORT_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort); // R8

    AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_alt || err_sync) |-> done); // R8

    AST_END_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || abort) |-> !watching); // R8

    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (!watching && sync_start) |=> watching); // R2

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !watching |=> !(done || abort)); // R2

    AST_READY_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (watching && lad_in == 4'b0000) |=> (done && !rdy_alt && !err_sync)); // R6

    AST_READY_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (watching && lad_in == 4'b1001) |=> (done && rdy_alt)); // R6

    AST_ERROR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (watching && lad_in == 4'b1010) |=> (done && err_sync && !rdy_alt)); // R7

    AST_LONG_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (watching && lad_in == 4'b0110) |=> (!abort && !done && watching)); // R5

endmodule

bind lpc_sync_watch lpc_sync_watch_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_start (sync_start),
    .lad_in     (lad_in),
    .watching   (watching),
    .done       (done),
    .abort      (abort),
    .rdy_alt    (rdy_alt),
    .err_sync   (err_sync)
);

// File: tb/lpc_sync_watch_tb.sv
module lpc_sync_watch_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_start = 1'b0;
    logic [3:0] lad_in = 4'hF;
    logic       done, abort, rdy_alt, err_sync;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    bit m_active = 0;
    int m_miss   = 0;
    int m_short  = 0;

    lpc_sync_watch u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_start (sync_start),
        .lad_in     (lad_in),
        .done       (done),
        .abort      (abort),
        .rdy_alt    (rdy_alt),
        .err_sync   (err_sync)
    );

    always #10 clk = ~clk;

    function automatic bit is_legal(logic [3:0] n);
        return n == 4'b0000 || n == 4'b0101 || n == 4'b0110 ||
               n == 4'b1001 || n == 4'b1010;
    endfunction

    function automatic logic [3:0] rand_illegal();
        logic [3:0] n;
        n = 4'($urandom_range(0, 15));
        while (is_legal(n)) n = 4'($urandom_range(0, 15));
        return n;
    endfunction

    task automatic cmp(string tag, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // drive one clock of stimulus at a falling edge, advance the model,
    // then compare at the next falling edge (one register after the decision)
    task automatic tick(bit start, logic [3:0] nib);
        logic e_done, e_abort, e_alt, e_err;
        string tag;
        e_done = 0; e_abort = 0; e_alt = 0; e_err = 0;
        tag = "R2";
        sync_start = start;
        lad_in     = nib;
        if (!m_active) begin
            if (start) begin
                m_active = 1; m_miss = 0; m_short = 0;
            end
        end else begin
            case (nib)
                4'b0000: begin e_done = 1; tag = "R6"; end
                4'b1001: begin e_done = 1; e_alt = 1; tag = "R6"; end
                4'b1010: begin e_done = 1; e_err = 1; tag = "R7"; end
                4'b0101: begin
                    m_miss = 0; m_short++; tag = "R4";
                    if (m_short == 9) e_abort = 1;
                end
                4'b0110: begin m_miss = 0; m_short = 0; tag = "R5"; end
                default: begin
                    m_short = 0; m_miss++; tag = "R3";
                    if (m_miss == 3) e_abort = 1;
                end
            endcase
            if (e_done || e_abort) m_active = 0;
        end
        @(negedge clk);
        cmp(tag, "done", done, e_done);
        cmp(tag, "abort", abort, e_abort);
        cmp(tag, "rdy_alt", rdy_alt, e_alt);
        cmp(tag, "err_sync", err_sync, e_err);
        cmp("R8", "excl", done & abort, 1'b0);
    endtask

    task automatic run_short(int n, logic [3:0] tail);
        tick(1, 4'hF);
        for (int i = 0; i < n; i++) tick(0, 4'b0101);
        tick(0, tail);
    endtask

    function automatic logic [3:0] rand_nib();
        int r;
        r = $urandom_range(0, 99);
        if (r < 30) return 4'b0101;
        if (r < 52) return 4'b0110;
        if (r < 70) return rand_illegal();
        if (r < 80) return 4'b0000;
        if (r < 90) return 4'b1001;
        return 4'b1010;
    endfunction

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "done", done, 1'b0);
        cmp("R1", "abort", abort, 1'b0);
        cmp("R1", "rdy_alt", rdy_alt, 1'b0);
        cmp("R1", "err_sync", err_sync, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: LAD traffic while idle has no effect
        tick(0, 4'b0000); tick(0, 4'b1010); tick(0, 4'b0011);
        // R6: plain and alternate ready
        tick(1, 4'b0000); tick(0, 4'b0000);
        tick(1, 4'b0000); tick(0, 4'b1001);
        // R7: error code
        tick(1, 4'b0000); tick(0, 4'b1010);
        // R4: eight short waits pass, nine abort
        run_short(8, 4'b0000);
        run_short(9, 4'b0000);
        tick(0, 4'b0000);
        // R3: two misses then legal then two misses survives; three abort
        tick(1, 4'b0); tick(0, 4'b0001); tick(0, 4'b1111); tick(0, 4'b0110);
        tick(0, 4'b0011); tick(0, 4'b1100); tick(0, 4'b1001);
        tick(1, 4'b0); tick(0, 4'b0001); tick(0, 4'b0010); tick(0, 4'b0100);
        // R3/R4: a miss breaks a short run; 8+1 then 8 more is fine
        tick(1, 4'b0);
        for (int i = 0; i < 8; i++) tick(0, 4'b0101);
        tick(0, 4'b1110);
        for (int i = 0; i < 8; i++) tick(0, 4'b0101);
        tick(0, 4'b0000);
        // R5: long wait has no limit; R2: start while armed ignored
        tick(1, 4'b0);
        for (int i = 0; i < 200; i++) tick(i % 37 == 5, 4'b0110);
        tick(0, 4'b1001);
        // R2: start in same cycle as a done is ignored, new phase later
        tick(1, 4'b0); tick(1, 4'b0000); tick(1, 4'b0101); tick(0, 4'b0000);

        // constrained random
        for (int t = 0; t < 1500; t++) begin
            int gap, len;
            gap = $urandom_range(0, 3);
            for (int g = 0; g < gap; g++) tick(0, 4'($urandom_range(0, 15)));
            tick(1, 4'($urandom_range(0, 15)));
            len = 0;
            while (m_active && len < 60) begin
                tick($urandom_range(0, 9) == 0, rand_nib());
                len++;
            end
            if (m_active) tick(0, 4'b0000);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule